// File: doc/BRIEF.md
# Frequency-Target Voltage Controller

This block is the slow outer loop of a supply-margin scheme. A fast inner controller moves the core clock so that timing margin stays near its setpoint. The inner controller also caps the clock one resolution step (28 MHz) above a target frequency. This block watches the resulting real frequency and moves the supply voltage code so that the real frequency settles just at or above the target. A clock held at its cap shows that the silicon has spare margin, so the voltage goes down. A clock below the target calls for more voltage. Anywhere in between, the voltage is left alone.

Once per programmable control interval the block compares the measured frequency with the target. It then issues at most one signed voltage step to the regulator over a valid/ready handshake. Its own copy of the voltage code moves only when a step is accepted. Every step is clipped so that the code never leaves a programmable window, and a flag shows when the code sits on either edge of that window.

Top module: `vtrim_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `vcode` equals RESET_CODE (default 128), `vreg_valid` is 0 and `vreg_step` is 0.
- R2: The frequency is judged only in the last cycle of each window of `cfg_interval` cycles (a value of 0 acts as 1). A new request raises `vreg_valid` in the following cycle, so at most one request starts per window.
- R3: When `meas_freq < cfg_target` at a judging cycle, the request carries a positive step of magnitude VSTEP (default 2).
- R4: When `meas_freq >= cfg_target + 28` at a judging cycle, the request carries a negative step (two's complement, STEP_W bits).
- R5: When `cfg_target <= meas_freq < cfg_target + 28`, no request is raised and `vcode` stays unchanged.
- R6: While `vreg_valid` is 1 and `vreg_ready` is 0, `vreg_valid` stays 1 and `vreg_step` stays unchanged. Judging cycles in that time raise no further request.
- R7: `vcode` changes only in the cycle after a handshake (`vreg_valid` and `vreg_ready` both 1), and it changes by exactly `vreg_step`. After a handshake `vreg_valid` falls, unless R10 raises a new request.
- R8: A step's magnitude is the smaller of VSTEP and the distance from the code to the limit it heads for (`cfg_vmax` upward, `cfg_vmin` downward). If that distance is 0, no request is raised.
- R9: `at_limit` is 1 exactly when `vcode >= cfg_vmax` or `vcode <= cfg_vmin`.
- R10: When a handshake completes in a judging cycle, a new request may be raised in the same edge. Its limit distance is measured from the code after the accepted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_target | input | FREQ_W | Target frequency, MHz |
| cfg_interval | input | INTV_W | Control interval length in cycles |
| cfg_vmin | input | CODE_W | Lowest allowed voltage code |
| cfg_vmax | input | CODE_W | Highest allowed voltage code |
| meas_freq | input | FREQ_W | Real frequency from the inner loop, MHz |
| vreg_ready | input | 1 | Regulator accepts the step |
| vreg_valid | output | 1 | Step request pending |
| vreg_step | output | STEP_W | Signed voltage step |
| vcode | output | CODE_W | Present voltage code |
| at_limit | output | 1 | Code sits at or beyond a limit |

## Verification
Two events can fall in the same cycle: the regulator accepting a pending step and the interval timer reaching its judging cycle. The limit distance for the next step must then come from the already-updated code. The bench provokes this by using intervals of 0 and 1, which make every cycle a judging cycle, with the ready line held high. A random phase then mixes short intervals with randomly dropped ready. A cycle model written from the requirements predicts the code, the request and the step in every cycle. Near-limit windows one code wide confirm that the clipped step lands exactly on the limit.

// File: rtl/vtrim_pkg.sv
package vtrim_pkg;
   typedef enum logic [1:0] {
      DIR_HOLD = 2'b00,
      DIR_UP   = 2'b01,
      DIR_DOWN = 2'b10
   } vdir_e;
endpackage

// File: rtl/vtrim_interval_timer.sv
module vtrim_interval_timer #(
   parameter int INTV_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INTV_W-1:0] interval,
   output logic              tick
);
   if (INTV_W < 1) begin : g_bad_w
      $error("vtrim_interval_timer: INTV_W must be at least 1");
   end

   logic [INTV_W-1:0] cnt_q;
   logic [INTV_W-1:0] last_idx;

   always_comb begin
      last_idx = (interval == '0) ? '0 : interval - 1'b1;
      tick     = (cnt_q >= last_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0)) else $error("timer did not restart"); // R2
endmodule

// File: rtl/vtrim_freq_classifier.sv
module vtrim_freq_classifier
   import vtrim_pkg::*;
#(
   parameter int FREQ_W     = 14,
   parameter int CEIL_MHZ   = 28,
   parameter bit SAMPLE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] target,
   input  logic [FREQ_W-1:0] meas,
   output vdir_e             dir
);
   localparam int CMP_W = FREQ_W + 1;

   if (CEIL_MHZ < 1 || CEIL_MHZ >= (1 << FREQ_W)) begin : g_bad_ceil
      $error("vtrim_freq_classifier: CEIL_MHZ out of range");
   end

   logic [FREQ_W-1:0] meas_use;

   if (SAMPLE_REG) begin : g_reg
      logic [FREQ_W-1:0] meas_q;
      always_ff @(posedge clk) begin
         if (!rst_n) meas_q <= '0;
         else meas_q <= meas;
      end
      assign meas_use = meas_q;
   end else begin : g_direct
      assign meas_use = meas;
   end

   logic [CMP_W-1:0] ceil_w;
   logic [CMP_W-1:0] meas_w;

   always_comb begin
      ceil_w = {1'b0, target} + CMP_W'(CEIL_MHZ);
      meas_w = {1'b0, meas_use};
      if (meas_use < target) dir = DIR_UP;
      else if (meas_w >= ceil_w) dir = DIR_DOWN;
      else dir = DIR_HOLD;
   end
endmodule

// File: rtl/vtrim_step_issuer.sv
module vtrim_step_issuer
   import vtrim_pkg::*;
#(
   parameter int CODE_W     = 8,
   parameter int STEP_W     = 4,
   parameter int VSTEP      = 2,
   parameter int RESET_CODE = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  vdir_e                    dir,
   input  logic [CODE_W-1:0]        vmin,
   input  logic [CODE_W-1:0]        vmax,
   input  logic                     req_ready,
   output logic                     req_valid,
   output logic signed [STEP_W-1:0] req_step,
   output logic [CODE_W-1:0]        code
);
   localparam int SUM_W = CODE_W + 2;
   localparam logic [CODE_W-1:0] VSTEP_C = CODE_W'(VSTEP);

   if (STEP_W < 2 || STEP_W > CODE_W) begin : g_bad_step_w
      $error("vtrim_step_issuer: STEP_W must lie in 2..CODE_W");
   end
   if (VSTEP < 1 || VSTEP >= (1 << (STEP_W - 1))) begin : g_bad_vstep
      $error("vtrim_step_issuer: VSTEP does not fit the signed step");
   end
   if (RESET_CODE < 0 || RESET_CODE >= (1 << CODE_W)) begin : g_bad_rst
      $error("vtrim_step_issuer: RESET_CODE out of range");
   end

   logic                     valid_q;
   logic signed [STEP_W-1:0] step_q;
   logic [CODE_W-1:0]        code_q;

   logic                     fire;
   logic                     pending;
   logic signed [SUM_W-1:0]  sum_s;
   logic [CODE_W-1:0]        code_now;
   logic [CODE_W-1:0]        room;
   logic [CODE_W-1:0]        mag;
   logic [STEP_W-1:0]        mag_n;
   logic                     issue;
   logic signed [STEP_W-1:0] step_new;

   always_comb begin
      fire     = valid_q && req_ready;
      pending  = valid_q && !req_ready;
      sum_s    = $signed({2'b00, code_q})
               + $signed({{(SUM_W - STEP_W){step_q[STEP_W-1]}}, step_q});
      code_now = fire ? sum_s[CODE_W-1:0] : code_q;
      unique case (dir)
         DIR_UP:   room = (vmax > code_now) ? vmax - code_now : '0;
         DIR_DOWN: room = (code_now > vmin) ? code_now - vmin : '0;
         default:  room = '0;
      endcase
      mag      = (room < VSTEP_C) ? room : VSTEP_C;
      mag_n    = mag[STEP_W-1:0];
      step_new = (dir == DIR_UP) ? $signed(mag_n) : $signed(-mag_n);
      issue    = tick && !pending && (dir != DIR_HOLD) && (mag != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         step_q  <= '0;
         code_q  <= CODE_W'(RESET_CODE);
      end else begin
         code_q <= code_now;
         if (issue) begin
            valid_q <= 1'b1;
            step_q  <= step_new;
         end else if (fire) begin
            valid_q <= 1'b0;
            step_q  <= '0;
         end
      end
   end

   assign req_valid = valid_q;
   assign req_step  = step_q;
   assign code      = code_q;

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !req_ready) |=> (valid_q && $stable(step_q))) else $error("step moved while stalled"); // R6
   AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q && req_ready) |=> $stable(code_q)) else $error("code moved without handshake"); // R7
   AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (step_q != '0)) else $error("zero step requested"); // R8
endmodule

// File: rtl/vtrim_ctrl.sv
module vtrim_ctrl
   import vtrim_pkg::*;
#(
   parameter int FREQ_W     = 14,
   parameter int INTV_W     = 12,
   parameter int CODE_W     = 8,
   parameter int STEP_W     = 4,
   parameter int VSTEP      = 2,
   parameter int CEIL_MHZ   = 28,
   parameter int RESET_CODE = 128,
   parameter bit SAMPLE_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FREQ_W-1:0]        cfg_target,
   input  logic [INTV_W-1:0]        cfg_interval,
   input  logic [CODE_W-1:0]        cfg_vmin,
   input  logic [CODE_W-1:0]        cfg_vmax,
   input  logic [FREQ_W-1:0]        meas_freq,
   input  logic                     vreg_ready,
   output logic                     vreg_valid,
   output logic signed [STEP_W-1:0] vreg_step,
   output logic [CODE_W-1:0]        vcode,
   output logic                     at_limit
);
   logic  tick;
   vdir_e dir;

   vtrim_interval_timer #(.INTV_W(INTV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .interval (cfg_interval),
      .tick     (tick)
   );

   vtrim_freq_classifier #(
      .FREQ_W     (FREQ_W),
      .CEIL_MHZ   (CEIL_MHZ),
      .SAMPLE_REG (SAMPLE_REG)
   ) u_classify (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (cfg_target),
      .meas   (meas_freq),
      .dir    (dir)
   );

   vtrim_step_issuer #(
      .CODE_W     (CODE_W),
      .STEP_W     (STEP_W),
      .VSTEP      (VSTEP),
      .RESET_CODE (RESET_CODE)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .dir       (dir),
      .vmin      (cfg_vmin),
      .vmax      (cfg_vmax),
      .req_ready (vreg_ready),
      .req_valid (vreg_valid),
      .req_step  (vreg_step),
      .code      (vcode)
   );

   assign at_limit = (vcode >= cfg_vmax) || (vcode <= cfg_vmin);

   AST_REQ_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vreg_valid) |-> $past(tick)) else $error("request outside judging cycle"); // R2
endmodule

// File: tb/vtrim_ctrl_bench.sv
module vtrim_ctrl_bench;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [13:0]       cfg_target = 14'd1000;
   logic [11:0]       cfg_interval = 12'd4;
   logic [7:0]        cfg_vmin = 8'd100;
   logic [7:0]        cfg_vmax = 8'd200;
   logic [13:0]       meas_freq = 14'd1010;
   logic              vreg_ready = 1'b1;
   logic              vreg_valid;
   logic signed [3:0] vreg_step;
   logic [7:0]        vcode;
   logic              at_limit;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // next-cycle stimulus
   int nx_target = 1000, nx_interval = 4, nx_vmin = 100, nx_vmax = 200;
   int nx_meas = 1010;
   bit nx_ready = 1'b1;

   // reference model state
   int m_cnt = 0, m_code = 128, m_step = 0;
   bit m_valid = 1'b0;

   always #4 clk = ~clk;

   vtrim_ctrl u_vtrim_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_target(cfg_target), .cfg_interval(cfg_interval),
      .cfg_vmin(cfg_vmin), .cfg_vmax(cfg_vmax), .meas_freq(meas_freq),
      .vreg_ready(vreg_ready), .vreg_valid(vreg_valid), .vreg_step(vreg_step),
      .vcode(vcode), .at_limit(at_limit)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int dir_of(input int meas, input int tgt);
      if (meas < tgt) return 1;
      if (meas >= tgt + 28) return -1;
      return 0;
   endfunction

   function automatic int mag_of(input int d, input int code, input int lo, input int hi);
      int room;
      room = 0;
      if (d > 0 && hi > code) room = hi - code;
      if (d < 0 && code > lo) room = code - lo;
      return (room < 2) ? room : 2;
   endfunction

   task automatic model_step();
      int last, d, mg, code_now;
      bit tick, fire, pend, issue;
      last = (cfg_interval == 0) ? 0 : int'(cfg_interval) - 1;
      tick = (m_cnt >= last);
      fire = m_valid && vreg_ready;
      pend = m_valid && !vreg_ready;
      code_now = fire ? ((m_code + m_step) & 255) : m_code;
      d = dir_of(int'(meas_freq), int'(cfg_target));
      mg = mag_of(d, code_now, int'(cfg_vmin), int'(cfg_vmax));
      issue = tick && !pend && d != 0 && mg != 0;
      m_code = code_now;
      if (issue) begin
         m_valid = 1'b1;
         m_step = d * mg;
      end else if (fire) begin
         m_valid = 1'b0;
         m_step = 0;
      end
      m_cnt = tick ? 0 : m_cnt + 1;
   endtask

   task automatic compare_all();
      bit exp_lim;
      chk("R7 code", int'(vcode), m_code);
      chk("R2 request valid", int'(vreg_valid), int'(m_valid));
      if (m_valid) begin
         if (m_step > 0) chk("R3 R8 up step", int'(vreg_step), m_step);
         else chk("R4 R8 down step", int'(vreg_step), m_step);
      end
      exp_lim = (m_code >= int'(cfg_vmax)) || (m_code <= int'(cfg_vmin));
      chk("R9 limit flag", int'(at_limit), int'(exp_lim));
   endtask

   task automatic cycle();
      @(negedge clk);
      compare_all();
      cfg_target   = 14'(nx_target);
      cfg_interval = 12'(nx_interval);
      cfg_vmin     = 8'(nx_vmin);
      cfg_vmax     = 8'(nx_vmax);
      meas_freq    = 14'(nx_meas);
      vreg_ready   = nx_ready;
      model_step();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   initial begin
      int start, rises;
      bit prev;
      void'($urandom(32'd2011));
      repeat (4) @(negedge clk);
      chk("R1 reset code", int'(vcode), 128);
      chk("R1 reset valid", int'(vreg_valid), 0);
      chk("R1 reset step", int'(vreg_step), 0);
      rst_n = 1'b1;
      model_step();
      @(negedge clk);
      chk("R1 first cycle code", int'(vcode), 128);
      chk("R1 first cycle valid", int'(vreg_valid), 0);
      model_step();

      // ceiling exactly reached: lower the voltage
      nx_meas = 1028;
      run(40);
      chk("R4 code lowered at ceiling", int'(vcode < 8'd128), 1);

      // one below ceiling: hold
      nx_meas = 1027;
      run(4);
      start = int'(vcode);
      run(40);
      chk("R5 code held inside band", int'(vcode), start);
      chk("R5 no request inside band", int'(vreg_valid), 0);

      // just below target: raise
      nx_meas = 999;
      run(40);
      chk("R3 code raised below target", int'(int'(vcode) > start), 1);

      // window edge one code away: clipped step
      nx_vmax = int'(vcode) + 1;
      run(40);
      chk("R8 clipped onto limit", int'(vcode), nx_vmax);
      chk("R9 flag at upper limit", int'(at_limit), 1);

      // stalled regulator
      nx_vmax = 250; nx_meas = 900; nx_ready = 1'b0;
      run(10);
      start = int'(vcode);
      run(30);
      chk("R6 code frozen while stalled", int'(vcode), start);
      chk("R6 request held while stalled", int'(vreg_valid), 1);
      nx_ready = 1'b1;
      run(10);

      // one request per interval
      nx_interval = 5; rises = 0; prev = vreg_valid;
      run(6);
      for (int i = 0; i < 50; i++) begin
         cycle();
         if (vreg_valid && !prev) rises++;
         prev = vreg_valid;
      end
      chk("R2 requests per 50 cycles in [9,10]", int'(rises >= 9 && rises <= 10), 1);

      // judging every cycle: handshake and judgement coincide
      nx_interval = 1;
      run(2);
      start = int'(vcode);
      run(20);
      chk("R10 back-to-back steps", int'(int'(vcode) - start >= 30), 1);
      nx_interval = 0;
      run(20);

      // constrained random
      for (int blk = 0; blk < 30; blk++) begin
         nx_target   = 500 + int'($urandom_range(0, 3000));
         nx_interval = int'($urandom_range(0, 6));
         nx_vmin     = int'($urandom_range(20, 120));
         nx_vmax     = nx_vmin + int'($urandom_range(0, 60));
         for (int i = 0; i < 100; i++) begin
            nx_meas  = nx_target + int'($urandom_range(0, 80)) - 40;
            nx_ready = ($urandom_range(0, 9) < 7);
            cycle();
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule